// File: doc/BRIEF.md
# Intermittent Fault Burst Saboteur

This block is placed in series on a data signal or bus and is transparent in normal operation. When a fault experiment needs it, a single arm strobe makes it inject one burst of intermittent faults. The burst has a random number of activations, and each one is followed by a quiet gap before the next. Each activation and each gap has its own random length. While an activation lasts, the bits chosen by a target mask are corrupted according to a selected fault model. Several mask bits set together give a simultaneous multiple fault.

The block runs on a fast tick clock with ten ticks per system clock cycle, so a window can be shorter than one system cycle. All random values come from an internal 16-bit linear feedback shift register that is loaded from a seed input when a burst is armed. This makes every burst repeatable from its seed. The controller is a five-state machine. ST_IDLE passes data and waits for arm. On accept, it goes from ST_IDLE to ST_SETUP. In ST_SETUP it draws the burst length and the first window, then goes to ST_ACTIVE. When a window ends with activations still pending, it goes from ST_ACTIVE to ST_GAP. When the gap ends, it goes from ST_GAP to ST_ACTIVE. When the last activation ends, it goes from ST_ACTIVE to ST_FINISH. ST_FINISH lasts one tick and signals completion, then the machine returns to ST_IDLE.

Top module: `burst_saboteur`

## Requirements
- R1: Outside the ST_ACTIVE state (idle, setup, gap, finish), data_out equals data_in on every bit.
- R2: arm is accepted only in ST_IDLE. An arm seen while busy or done is high is ignored: it does not change the running burst, its seed, its model or its mask. busy is high in ST_SETUP, ST_ACTIVE and ST_GAP.
- R3: The number of activations is ((L[15:8]) mod 10) + 1, where L is the register value in ST_SETUP, so it lies between 1 and 10. No gap follows the last activation: done rises on the tick right after the last active tick.
- R4: Every activation and every gap lasts (V mod 10) + 1 ticks, where V is the 16-bit register value on the tick the window is drawn. The first window is drawn in ST_SETUP, and each later window on the last tick of the window before it. Every window is therefore 1 to 10 ticks long.
- R5: The random register is a right-shifting Galois register with feedback mask 0xB400. It is loaded on accept with the seed, or with 0x0001 when the seed is zero. It steps once on every tick the machine is out of ST_IDLE.
- R6: fault_sel is latched on accept. Its codes are: 0 forces 0, 1 forces 1, 2 inverts the bit, 3 holds the open value, 4 drives bit i of the random register (index taken mod 16). Codes 5 to 7 leave the data unchanged.
- R7: Only bits set in the mask latched on accept are altered, and all of them are altered in the same ticks.
- R8: In model 3, the masked bits carry the value data_in had on the tick just before the activation began.
- R9: done is high for exactly one tick per burst, and busy is low during that tick. The next tick is ST_IDLE.
- R10: After reset, busy and done are low and data_out follows data_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, ten ticks per system cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Starts one burst when sampled high in ST_IDLE |
| fault_sel | input | 3 | Fault model code, latched on accept |
| bit_mask | input | WIDTH | Bits to corrupt, latched on accept |
| seed | input | 16 | Start value for the random register |
| data_in | input | WIDTH | Signal entering the saboteur |
| data_out | output | WIDTH | Signal leaving the saboteur |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-tick pulse at the end of a burst |

## Verification
The assertions take for granted that arm, fault_sel, bit_mask and seed are synchronous to the tick clock and are sampled only at a rising edge. They also assume that data_in may change on any tick, and that the fault models 5 to 7 pass data through. The stimulus changes every input half a tick after a rising edge, so nothing moves near a sampling edge. It fires arm strobes inside running bursts to exercise the ignore rule. It mixes directed bursts, including a zero seed, an empty mask and a full mask, with bursts whose seed, model, mask and per-tick data are random.

// File: rtl/burst_sab_pkg.sv
package burst_sab_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_ACTIVE = 3'd2,
        ST_GAP    = 3'd3,
        ST_FINISH = 3'd4
    } sab_state_t;

    localparam logic [2:0] FM_STUCK0 = 3'd0;
    localparam logic [2:0] FM_STUCK1 = 3'd1;
    localparam logic [2:0] FM_INVERT = 3'd2;
    localparam logic [2:0] FM_HOLD   = 3'd3;
    localparam logic [2:0] FM_NOISE  = 3'd4;

    localparam int RNG_W = 16;

endpackage

// File: rtl/burst_sab_lfsr.sv
module burst_sab_lfsr
    import burst_sab_pkg::*;
#(
    parameter logic [RNG_W-1:0] TAPS = 16'hB400,
    parameter logic [RNG_W-1:0] ZERO_SUB = 16'h0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [RNG_W-1:0] seed_i,
    output logic [RNG_W-1:0] value_o
);

    logic [RNG_W-1:0] reg_q;
    logic [RNG_W-1:0] seed_nz;
    logic [RNG_W-1:0] shifted;

    always_comb begin
        seed_nz = (seed_i == '0) ? ZERO_SUB : seed_i;
        shifted = reg_q[0] ? ((reg_q >> 1) ^ TAPS) : (reg_q >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= ZERO_SUB;
        end else if (load_i) begin
            reg_q <= seed_nz;
        end else if (step_i) begin
            reg_q <= shifted;
        end
    end

    assign value_o = reg_q;

    // A zero state would lock the generator.
    assert_never_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_q != '0)
        else $error("random register reached zero");

    assert_load_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i != '0) |=> (reg_q == $past(seed_i)))
        else $error("seed not loaded");

endmodule

// File: rtl/burst_sab_ctrl.sv
module burst_sab_ctrl
    import burst_sab_pkg::*;
#(
    parameter int MAX_BURST = 10,
    parameter int MAX_WIN   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [RNG_W-1:0] rng_i,
    output logic             accept_o,
    output logic             step_o,
    output logic             active_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int LEN_W = $clog2(MAX_BURST + 1);
    localparam int WIN_W = $clog2(MAX_WIN + 1);
    localparam logic [RNG_W-1:0] LEN_MOD = RNG_W'(MAX_BURST);
    localparam logic [RNG_W-1:0] WIN_MOD = RNG_W'(MAX_WIN);

    sab_state_t       state_q, state_d;
    logic [LEN_W-1:0] left_q, left_d;
    logic [WIN_W-1:0] timer_q, timer_d;

    logic [RNG_W-1:0] len_rem;
    logic [RNG_W-1:0] win_rem;
    logic [LEN_W-1:0] len_draw;
    logic [WIN_W-1:0] win_draw;

    always_comb begin
        len_rem  = {8'h00, rng_i[15:8]} % LEN_MOD;
        win_rem  = rng_i % WIN_MOD;
        len_draw = LEN_W'(len_rem) + LEN_W'(1);
        win_draw = WIN_W'(win_rem) + WIN_W'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            timer_q <= timer_d;
        end
    end

    // next state and counters
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        timer_d = timer_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_i) begin
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP: begin
                left_d  = len_draw;
                timer_d = win_draw;
                state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (timer_q == WIN_W'(1)) begin
                    if (left_q == LEN_W'(1)) begin
                        state_d = ST_FINISH;
                        left_d  = '0;
                        timer_d = '0;
                    end else begin
                        left_d  = left_q - LEN_W'(1);
                        timer_d = win_draw;
                        state_d = ST_GAP;
                    end
                end else begin
                    timer_d = timer_q - WIN_W'(1);
                end
            end
            ST_GAP: begin
                if (timer_q == WIN_W'(1)) begin
                    timer_d = win_draw;
                    state_d = ST_ACTIVE;
                end else begin
                    timer_d = timer_q - WIN_W'(1);
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        accept_o = 1'b0;
        step_o   = 1'b1;
        active_o = 1'b0;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept_o = arm_i;
                step_o   = 1'b0;
            end
            ST_SETUP:  busy_o = 1'b1;
            ST_ACTIVE: begin
                busy_o   = 1'b1;
                active_o = 1'b1;
            end
            ST_GAP:    busy_o = 1'b1;
            ST_FINISH: done_o = 1'b1;
            default:   step_o = 1'b0;
        endcase
    end

    assert_timer_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE || state_q == ST_GAP) |->
            (timer_q >= WIN_W'(1) && timer_q <= WIN_W'(MAX_WIN)))
        else $error("window timer out of range");

    assert_left_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE || state_q == ST_GAP) |->
            (left_q >= LEN_W'(1) && left_q <= LEN_W'(MAX_BURST)))
        else $error("activation count out of range");

    assert_finish_after_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(active_o))
        else $error("trailing gap before done");

    assert_done_one_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o && state_q == ST_IDLE))
        else $error("done longer than one tick");

    assert_arm_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && arm_i) |=> (state_q != ST_SETUP))
        else $error("arm accepted while busy");

    assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, done_o}))
        else $error("busy and done together");

endmodule

// File: rtl/burst_sab_corrupt.sv
module burst_sab_corrupt
    import burst_sab_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [2:0]       model_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic [RNG_W-1:0] rng_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] data_o
);

    logic [WIDTH-1:0] hold_q;

    // open value: the input of the last tick before the activation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (!active_i) begin
            hold_q <= data_i;
        end
    end

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic fault_bit;
        logic hit;
        always_comb begin
            hit = active_i && mask_i[gi];
            case (model_i)
                FM_STUCK0: fault_bit = 1'b0;
                FM_STUCK1: fault_bit = 1'b1;
                FM_INVERT: fault_bit = ~data_i[gi];
                FM_HOLD:   fault_bit = hold_q[gi];
                FM_NOISE:  fault_bit = rng_i[gi % RNG_W];
                default:   fault_bit = data_i[gi];
            endcase
            data_o[gi] = hit ? fault_bit : data_i[gi];
        end
    end

    assert_pass_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |-> (data_o == data_i))
        else $error("data altered outside activation");

    assert_unmasked_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_o ^ data_i) & ~mask_i) == '0)
        else $error("unmasked bit altered");

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && $past(active_i)) |-> $stable(hold_q))
        else $error("open value moved during activation");

endmodule

// File: rtl/burst_saboteur.sv
module burst_saboteur
    import burst_sab_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int MAX_BURST = 10,
    parameter int MAX_WIN   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [2:0]       fault_sel,
    input  logic [WIDTH-1:0] bit_mask,
    input  logic [15:0]      seed,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] data_out,
    output logic             busy,
    output logic             done
);

    logic             accept;
    logic             step;
    logic             active;
    logic [RNG_W-1:0] rng;
    logic [2:0]       model_q;
    logic [WIDTH-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_q <= FM_STUCK0;
            mask_q  <= '0;
        end else if (accept) begin
            model_q <= fault_sel;
            mask_q  <= bit_mask;
        end
    end

    burst_sab_lfsr u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .step_i  (step),
        .seed_i  (seed),
        .value_o (rng)
    );

    burst_sab_ctrl #(
        .MAX_BURST (MAX_BURST),
        .MAX_WIN   (MAX_WIN)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm),
        .rng_i    (rng),
        .accept_o (accept),
        .step_o   (step),
        .active_o (active),
        .busy_o   (busy),
        .done_o   (done)
    );

    burst_sab_corrupt #(
        .WIDTH (WIDTH)
    ) u_corrupt (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .model_i  (model_q),
        .mask_i   (mask_q),
        .rng_i    (rng),
        .data_i   (data_in),
        .data_o   (data_out)
    );

    assert_settings_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || done) |=> (busy || done || $past(done)) |-> ($stable(mask_q) && $stable(model_q)))
        else $error("settings changed during burst");

    assert_accept_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (!busy && !done))
        else $error("accept outside idle");

endmodule

// File: tb/burst_saboteur_bench.sv
module burst_saboteur_bench;

    localparam int TCK = 10;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic [2:0]    fault_sel = 3'd0;
    logic [W-1:0]  bit_mask = '0;
    logic [15:0]   seed = 16'h0;
    logic [W-1:0]  data_in = '0;
    logic [W-1:0]  data_out;
    logic          busy;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(TCK/2) clk = ~clk;

    burst_saboteur u_burst_saboteur (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .fault_sel (fault_sel),
        .bit_mask  (bit_mask),
        .seed      (seed),
        .data_in   (data_in),
        .data_out  (data_out),
        .busy      (busy),
        .done      (done)
    );

    // reference state: 0 idle, 1 setup, 2 active, 3 gap, 4 finish
    int          m_st = 0;
    logic [15:0] m_rng = 16'h0001;
    int          m_left = 0;
    int          m_timer = 0;
    logic [W-1:0] m_hold = '0;
    logic [2:0]  m_model = 3'd0;
    logic [W-1:0] m_mask = '0;

    // port-level measurement
    bit meas_on = 1'b0;
    int run_len = 0;
    int runs = 0;
    bit prev_diff = 1'b0;

    function automatic logic [15:0] rng_next(input logic [15:0] x);
        return x[0] ? ((x >> 1) ^ 16'hB400) : (x >> 1);
    endfunction

    function automatic int win_draw(input logic [15:0] x);
        return int'(x % 16'd10) + 1;
    endfunction

    function automatic int len_draw(input logic [15:0] x);
        return int'({8'h00, x[15:8]} % 16'd10) + 1;
    endfunction

    function automatic logic [W-1:0] exp_out(input logic [W-1:0] din);
        logic [W-1:0] f;
        if (m_st != 2) return din;
        case (m_model)
            3'd0: f = '0;
            3'd1: f = '1;
            3'd2: f = ~din;
            3'd3: f = m_hold;
            3'd4: f = m_rng;
            default: f = din;
        endcase
        return (din & ~m_mask) | (f & m_mask);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input bit a, input logic [2:0] sel, input logic [W-1:0] msk,
                        input logic [15:0] sd, input logic [W-1:0] din);
        logic [W-1:0] eo;
        bit eb, ed, diff;
        @(negedge clk);
        arm = a; fault_sel = sel; bit_mask = msk; seed = sd; data_in = din;
        #1;
        eo = exp_out(din);
        eb = (m_st == 1 || m_st == 2 || m_st == 3);
        ed = (m_st == 4);
        if (m_st == 2)
            check(data_out == eo, "R6 R7 R8 corrupted value", 32'(data_out), 32'(eo));
        else
            check(data_out == eo, "R1 pass-through", 32'(data_out), 32'(eo));
        check(busy == eb, "R2 busy", 32'(busy), 32'(eb));
        check(done == ed, "R9 done", 32'(done), 32'(ed));
        if (meas_on) begin
            diff = (data_out != data_in);
            if (diff) run_len++;
            else if (run_len > 0) begin
                check(run_len >= 1 && run_len <= 10, "R4 active window length", 32'(run_len), 32'd10);
                runs++;
                run_len = 0;
            end
            if (done) begin
                check(prev_diff, "R3 no trailing gap before done", 32'(prev_diff), 32'd1);
                check(runs >= 1 && runs <= 10, "R3 activation count", 32'(runs), 32'd10);
                meas_on = 1'b0;
            end
            prev_diff = diff;
        end
        // reference update for the coming edge
        if (m_st != 2) m_hold = din;
        case (m_st)
            0: if (a) begin
                   m_rng = (sd == 16'h0) ? 16'h0001 : sd;
                   m_model = sel; m_mask = msk; m_st = 1;
               end
            1: begin
                   m_left = len_draw(m_rng); m_timer = win_draw(m_rng);
                   m_st = 2; m_rng = rng_next(m_rng);
               end
            2: begin
                   if (m_timer == 1) begin
                       if (m_left == 1) m_st = 4;
                       else begin m_left--; m_timer = win_draw(m_rng); m_st = 3; end
                   end else m_timer--;
                   m_rng = rng_next(m_rng);
               end
            3: begin
                   if (m_timer == 1) begin m_timer = win_draw(m_rng); m_st = 2; end
                   else m_timer--;
                   m_rng = rng_next(m_rng);
               end
            default: begin m_st = 0; m_rng = rng_next(m_rng); end
        endcase
    endtask

    // run one burst to completion; optional second arm mid-burst
    task automatic burst(input logic [2:0] sel, input logic [W-1:0] msk, input logic [15:0] sd,
                         input int dmode, input bit rearm);
        int n;
        logic [W-1:0] d;
        d = (dmode == 0) ? '0 : W'($urandom);
        tick(1'b1, sel, msk, sd, d);
        n = 0;
        while ((m_st != 0) && n < 400) begin
            if (dmode == 2) d = W'($urandom);
            tick(rearm && (n == 3), 3'(~sel), ~msk, sd ^ 16'h5A5A, d);
            n++;
        end
        tick(1'b0, sel, msk, sd, d);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(negedge clk);
        // R10: reset state
        check(busy == 1'b0, "R10 busy after reset", 32'(busy), 32'd0);
        check(done == 1'b0, "R10 done after reset", 32'(done), 32'd0);
        data_in = 16'hBEEF; #1;
        check(data_out == 16'hBEEF, "R10 pass in reset", 32'(data_out), 32'hBEEF);
        @(negedge clk); rst_n = 1'b1;
        tick(1'b0, 3'd0, '0, 16'h0, 16'h1234);

        // R3 R4: port-level window measurement, stuck-at-1 on zero data, full mask
        for (int k = 0; k < 6; k++) begin
            meas_on = 1'b1; run_len = 0; runs = 0; prev_diff = 1'b0;
            burst(3'd1, '1, 16'(16'h1357 + k * 977), 0, 1'b0);
        end
        // R2: arm mid-burst with other settings
        burst(3'd2, 16'h00F0, 16'hACE1, 1, 1'b1);
        // R5: zero seed
        burst(3'd1, 16'h8001, 16'h0000, 1, 1'b0);
        // R7: empty mask
        burst(3'd2, 16'h0000, 16'h7777, 2, 1'b0);
        // R8: hold with moving data
        burst(3'd3, 16'hFFFF, 16'h2468, 2, 1'b0);
        // R6: noise and unused codes
        burst(3'd4, 16'hFFFF, 16'h9999, 2, 1'b0);
        burst(3'd6, 16'hFFFF, 16'h4321, 2, 1'b0);
        burst(3'd0, 16'hA5A5, 16'hFFFF, 1, 1'b0);
        // random bursts
        for (int k = 0; k < 30; k++) begin
            burst(3'($urandom_range(0, 7)), W'($urandom), 16'($urandom), 2, bit'($urandom_range(0, 1)));
            if ($urandom_range(0, 1) == 1) tick(1'b0, 3'd0, '0, 16'h0, W'($urandom));
        end
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R9 actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule